// File: doc/BRIEF.md
# Three-Stage Integer Pipeline with One Branch Delay Slot

This block is a small in-order integer core with three stages. The first stage fetches and decodes an instruction. The second stage executes it, and the third stage writes its result to the register file. Every instruction has the same width and the same fixed fields. The instruction set has six operations: compare, increment, load-immediate, add, conditional jump-if-not-equal, and no-operation. They act on a small register file and on a single equality flag.

The instruction store is a synchronous read-only array inside the block. It is filled through a write port before reset is released. A conditional jump is resolved in the execute stage, and the pipeline never discards an instruction. The instruction that follows a jump, its delay slot, always runs to completion. Only the fetch after the delay slot is steered to the jump target.

The core has two outputs. A retire strobe marks each instruction that finishes in the store stage. A debug read port exposes any register.

Top module: `pipe3_dslot`

## Requirements
- R1: While reset is low and in the first cycles after it is released, the program counter starts at 0, every register and the equality flag read 0, and `retire_o` stays low. It stays low until the first fetched instruction reaches the store stage, which is the third rising edge after release.
- R2: An instruction is 15 bits wide with the default parameters. The opcode is in [14:12], the destination/first-source register in [11:10], the second-source register in [9:8], and the immediate in [7:0]. The opcodes are 0 no-op, 1 compare, 2 increment, 3 load-immediate, 4 add and 5 jump-if-not-equal.
- R3: Increment writes rd+1 to rd. Load-immediate writes imm to rd. Add writes rd+rs to rd, modulo 2^XLEN.
- R4: Compare sets the flag to (rd == rs) at the end of its execute cycle. A jump in the very next instruction slot already sees the updated flag.
- R5: A jump-if-not-equal whose flag is clear is taken, and its target is the low address bits of imm. Whether or not the jump is taken, the single instruction after it always completes.
- R6: The instruction fetched after the delay slot comes from the target when the jump is taken, and from the next sequential address otherwise.
- R7: A jump writes nothing and raises no retire strobe. Every other fetched instruction raises `retire_o` for exactly one cycle when it is in the store stage.
- R8: A register written by one instruction is seen by the next instruction and by the one after that, through forwarding from the execute and store stages.
- R9: A no-op changes neither a register nor the flag.
- R10: With no jumps, one instruction retires every cycle.
- R11: A write on the instruction write port stores the word at the given address. The word is fetched from there later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_we | input | 1 | Instruction store write enable |
| imem_waddr | input | AW (5) | Instruction store write address |
| imem_wdata | input | IW (15) | Instruction word to store |
| dbg_sel | input | RA (2) | Register index for the debug port |
| dbg_data | output | XLEN (8) | Contents of the selected register |
| eq_o | output | 1 | Current equality flag |
| retire_o | output | 1 | An instruction completed in the store stage this cycle |

## Verification
The bench runs a loop program. In that program a compare is followed at once by a jump. The jump is taken on early iterations and falls through on the last one, and each jump has a live delay-slot instruction. Back-to-back and one-apart register dependences separate forwarding from the execute stage, forwarding from the store stage, and the register-file read. The run goes on through a long stretch of no-ops and wraps around the address space, which shows that no-ops leave the state alone and that retirement settles at one instruction per cycle. A behavioural interpreter of the instruction set, with delay-slot semantics, predicts the retire strobe, the flag and all four registers for every cycle.

// File: rtl/pipe3_dslot.sv
module pipe3_dslot #(
  parameter int XLEN       = 8,
  parameter int NREG       = 4,
  parameter int IMEM_DEPTH = 32,
  localparam int RA = $clog2(NREG),
  localparam int AW = $clog2(IMEM_DEPTH),
  localparam int IW = 3 + 2*RA + XLEN
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            imem_we,
  input  logic [AW-1:0]   imem_waddr,
  input  logic [IW-1:0]   imem_wdata,
  input  logic [RA-1:0]   dbg_sel,
  output logic [XLEN-1:0] dbg_data,
  output logic            eq_o,
  output logic            retire_o
);
  localparam logic [2:0] OP_NOP = 3'd0, OP_CMP = 3'd1, OP_INC = 3'd2,
                         OP_MOVI = 3'd3, OP_ADD = 3'd4, OP_JNE = 3'd5;

  logic [IW-1:0] imem [IMEM_DEPTH];
  logic [AW-1:0] pc, ir_pc, fetch_addr;
  logic [IW-1:0] ir;
  logic          ir_v;
  logic [NREG-1:0][XLEN-1:0] rf;
  logic          eq;

  logic [2:0]      d_op;
  logic [RA-1:0]   d_rd, d_rs;
  logic [XLEN-1:0] d_imm, opa, opb;

  logic            ex_v, ex_we, taken;
  logic [2:0]      ex_op;
  logic [RA-1:0]   ex_rd;
  logic [XLEN-1:0] ex_a, ex_b, ex_imm, ex_res;

  logic            st_v, st_we;
  logic [RA-1:0]   st_rd;
  logic [XLEN-1:0] st_res;

  always_ff @(posedge clk)
    if (imem_we) imem[imem_waddr] <= imem_wdata;

  assign taken      = ex_v && ex_op == OP_JNE && !eq;
  assign fetch_addr = taken ? ex_imm[AW-1:0] : pc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc <= '0; ir <= '0; ir_v <= 1'b0; ir_pc <= '0;
    end else begin
      ir    <= imem[fetch_addr];
      ir_pc <= fetch_addr;
      pc    <= fetch_addr + 1'b1;
      ir_v  <= 1'b1;
    end
  end

  assign d_op  = ir[IW-1 -: 3];
  assign d_rd  = ir[IW-4 -: RA];
  assign d_rs  = ir[IW-4-RA -: RA];
  assign d_imm = ir[XLEN-1:0];

  assign opa = (ex_we && ex_rd == d_rd) ? ex_res :
               (st_v && st_we && st_rd == d_rd) ? st_res : rf[d_rd];
  assign opb = (ex_we && ex_rd == d_rs) ? ex_res :
               (st_v && st_we && st_rd == d_rs) ? st_res : rf[d_rs];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ex_v <= 1'b0; ex_op <= OP_NOP; ex_rd <= '0;
      ex_a <= '0; ex_b <= '0; ex_imm <= '0;
    end else begin
      ex_v <= ir_v; ex_op <= d_op; ex_rd <= d_rd;
      ex_a <= opa;  ex_b <= opb;  ex_imm <= d_imm;
    end
  end

  assign ex_we = ex_v && (ex_op == OP_INC || ex_op == OP_MOVI || ex_op == OP_ADD);

  always_comb begin
    case (ex_op)
      OP_INC:  ex_res = ex_a + 1'b1;
      OP_MOVI: ex_res = ex_imm;
      OP_ADD:  ex_res = ex_a + ex_b;
      default: ex_res = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) eq <= 1'b0;
    else if (ex_v && ex_op == OP_CMP) eq <= (ex_a == ex_b);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_v <= 1'b0; st_we <= 1'b0; st_rd <= '0; st_res <= '0;
    end else begin
      st_v   <= ex_v && ex_op != OP_JNE;
      st_we  <= ex_we;
      st_rd  <= ex_rd;
      st_res <= ex_res;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rf <= '0;
    else if (st_v && st_we) rf[st_rd] <= st_res;
  end

  assign retire_o = st_v;
  assign dbg_data = rf[dbg_sel];
  assign eq_o     = eq;

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> !retire_o); // R1
  AST_JUMP_NO_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_v && ex_op == OP_JNE) |=> !retire_o); // R7
  AST_TAKEN_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_v && ex_op == OP_JNE && !eq) |=> ir_pc == $past(ex_imm[AW-1:0])); // R6
  AST_SEQ_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_v && !(ex_v && ex_op == OP_JNE && !eq)) |=> ir_pc == $past(ir_pc) + 1'b1); // R6
  AST_IDLE_RF_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !retire_o |=> $stable(rf)); // R9
endmodule

// File: tb/test_pipe3_dslot.sv
`timescale 1ns/1ps
module test_pipe3_dslot;
  localparam int NCYC = 150;
  localparam int NSTR = 200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        imem_we = 1'b0;
  logic [4:0]  imem_waddr = '0;
  logic [14:0] imem_wdata = '0;
  logic [1:0]  dbg_sel = '0;
  logic [7:0]  dbg_data;
  logic        eq_o, retire_o;

  int errors = 0, checks = 0;
  logic [14:0] prog [32];
  int  mr [NSTR+1][4];
  bit  mf [NSTR+1];
  int  mop [NSTR];

  always #2.5 clk = ~clk;

  pipe3_dslot i_pipe3_dslot (
    .clk(clk), .rst_n(rst_n), .imem_we(imem_we), .imem_waddr(imem_waddr),
    .imem_wdata(imem_wdata), .dbg_sel(dbg_sel), .dbg_data(dbg_data),
    .eq_o(eq_o), .retire_o(retire_o));

  // R2: field layout op[14:12] rd[11:10] rs[9:8] imm[7:0]
  function automatic logic [14:0] enc(int op, int rd, int rs, int imm);
    return {3'(op), 2'(rd), 2'(rs), 8'(imm)};
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_regs(string tag, int n);
    for (int r = 0; r < 4; r++) begin
      dbg_sel = 2'(r);
      #0.1;
      chk(tag, int'(dbg_data), mr[n][r]);
    end
  endtask

  // instruction-set interpreter with one delay slot
  task automatic build_model();
    int pc = 0, tgt = 0, a, b;
    bit redir = 0, nredir;
    int regs [4] = '{0, 0, 0, 0};
    bit flag = 0;
    for (int r = 0; r < 4; r++) mr[0][r] = 0;
    mf[0] = 0;
    for (int k = 0; k < NSTR; k++) begin
      int op, rd, rs, imm, nxt;
      op = prog[pc][14:12]; rd = prog[pc][11:10]; rs = prog[pc][9:8]; imm = prog[pc][7:0];
      mop[k] = op;
      a = regs[rd]; b = regs[rs];
      nredir = 0;
      case (op)
        1: flag = (a == b);
        2: regs[rd] = (a + 1) % 256;
        3: regs[rd] = imm;
        4: regs[rd] = (a + b) % 256;
        5: if (!flag) nredir = 1;
        default: ;
      endcase
      nxt = redir ? tgt : (pc + 1) % 32;
      redir = nredir;
      if (nredir) tgt = imm % 32;
      pc = nxt;
      for (int r = 0; r < 4; r++) mr[k+1][r] = regs[r];
      mf[k+1] = flag;
    end
  endtask

  initial begin
    int nret, nexp;
    for (int i = 0; i < 32; i++) prog[i] = '0;
    prog[0]  = enc(3, 0, 0, 0);     // r0 = 0
    prog[1]  = enc(3, 1, 0, 3);     // r1 = 3
    prog[2]  = enc(3, 2, 0, 0);     // r2 = 0
    prog[3]  = enc(3, 3, 0, 5);     // r3 = 5
    prog[4]  = enc(1, 0, 1, 0);     // cmp r0, r1
    prog[5]  = enc(5, 0, 0, 9);     // jne 9 (flag from previous slot, R4)
    prog[6]  = enc(2, 0, 0, 0);     // slot: inc r0 (R5)
    prog[7]  = enc(3, 2, 0, 8'h40); // fall-through only
    prog[8]  = enc(4, 2, 3, 0);     // add r2, r3 (EX forward, R8)
    prog[9]  = enc(4, 2, 3, 0);     // add r2, r3
    prog[10] = enc(5, 0, 0, 4);     // jne 4
    prog[11] = enc(4, 2, 0, 0);     // slot: add r2, r0 (ST forward, R8)
    prog[12] = enc(3, 3, 0, 8'h11);
    build_model();

    // R11: load the store through the write port while in reset
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      imem_we = 1'b1; imem_waddr = 5'(i); imem_wdata = prog[i];
    end
    @(negedge clk);
    imem_we = 1'b0;
    @(negedge clk);
    chk("R1 retire in reset", int'(retire_o), 0);
    chk("R1 flag in reset", int'(eq_o), 0);
    chk_regs("R1 regs in reset", 0);
    rst_n = 1'b1;

    nret = 0; nexp = 0;
    for (int p = 1; p <= NCYC; p++) begin
      int nreg, nflg, expret;
      @(posedge clk);
      @(negedge clk);
      nreg = (p >= 3) ? p - 3 : 0;
      nflg = (p >= 2) ? p - 2 : 0;
      expret = (p >= 3 && mop[p-3] != 5) ? 1 : 0;
      chk("R1/R7 retire strobe", int'(retire_o), expret);
      chk("R4 flag", int'(eq_o), int'(mf[nflg]));
      chk_regs("R3/R5/R6/R8/R9 register", nreg);
      if (p >= 3) begin nret += int'(retire_o); nexp += expret; end
    end
    // R10: total retirements equal the non-jump instruction count
    chk("R10 retire count", nret, nexp);
    chk("R10 steady-state retires", nret >= NCYC - 2 - 30 ? 1 : 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule